// File: doc/BRIEF.md
# Lattice-Reduced MIMO Symbol Detector with Puncturing Demapper

This block turns one received MIMO vector, taken from a single data tone, into hard-decision bit LLRs. The received vector is fixed point. The block multiplies it by a stored complex equalization matrix that works in a reduced lattice basis. Each equalized coordinate is then rounded onto the odd-integer grid, and the per-matrix block-floating-point exponent is removed by an extra right shift. The rounded vector is multiplied by a small complex integer transformation matrix, which brings it back to the original basis.

Each recovered complex point is then tested against the alphabet of the selected constellation. Valid points produce Gray-labelled LLRs of a fixed magnitude. A point that lies outside the alphabet produces all-zero LLRs for that stream, so a downstream decoder treats those bits as erased. The vector, both matrices, the exponent and the mode all come from a matrix cache. They are presented together on one `in_valid_i` cycle, and a new vector may arrive on every clock.

Top module: `lat_detector`

## Requirements
- R1: While `rst` is high and after its release, `out_valid_o` is 0 and every LLR slot is 0 until a result arrives.
- R2: A vector accepted with `in_valid_i` = 1 gives exactly one `out_valid_o` pulse 3 clocks later. Vectors may follow on consecutive clocks, and no output appears for cycles in which `in_valid_i` is low.
- R3: The equalized coordinate for stream r is the complex sum over k of W[r][k]·y[k]. Received values carry RX_FRAC fractional bits and matrix entries carry W_FRAC fractional bits.
- R4: Each equalized real or imaginary value v is divided by 2^e, where e is `bfp_exp_i`. The result is rounded to the nearest odd integer. An even value (a tie) goes away from zero, and zero goes to +1.
- R5: A rounded magnitude larger than QLIM = 2^(Q_W-1)-1 (31 by default) is clamped to QLIM, and the sign is kept.
- R6: The estimate for stream r is the complex sum over k of T[r][k]·q[k], where the entries of T are signed integers.
- R7: A coordinate is valid when it is odd and its magnitude is at most 1, 3 or 7 for modes 0 (4-QAM), 1 (16-QAM) and 2 (64-QAM). Mode 3 marks every symbol invalid.
- R8: If either coordinate of a stream's point is invalid, all six LLR slots of that stream are 0. Other streams are unaffected.
- R9: Stream r occupies slots r·6 to r·6+5, each LLR_W bits wide. Slots 0 to 2 hold bits b0 to b2 of the real coordinate a, and slots 3 to 5 hold the same bits for the imaginary coordinate. The bits are: b0 = (a<0); b1 = (|a|=1) in mode 1 and (|a|<4) in mode 2; b2 = (|a|=3 or 5) in mode 2. Bit 0 is output as +LLR_MAG and bit 1 as −LLR_MAG. Slots beyond the mode's 1, 2 or 3 bits per coordinate are 0.
- R10: The mode, exponent and transformation matrix of a vector apply to that vector only, even when vectors with other settings follow on the next clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Vector and matrices valid this cycle |
| rx_i | input | NS·2·IN_W | Received vector; element k real at index 2k, imaginary at 2k+1 |
| wmat_i | input | NS·NS·2·W_W | Equalization matrix; entry (r,k) real at index 2(r·NS+k) |
| tmat_i | input | NS·NS·2·T_W | Integer transformation matrix, same layout |
| bfp_exp_i | input | EXP_W | Block-floating-point exponent (extra right shift) |
| qam_mode_i | input | 2 | 0: 4-QAM, 1: 16-QAM, 2: 64-QAM, 3: reserved |
| out_valid_o | output | 1 | LLR vector valid |
| llr_o | output | NS·6·LLR_W | Signed LLR slots, layout per R9 |

## Verification
Two functions can act in the same output cycle. In one case, one stream of a vector is punctured while the other stream emits normal Gray LLRs. In the other case, a vector in one mode leaves the demapper on the same clock that a vector in a different mode, exponent and transformation enters the equalizer. The first case is provoked with a transformation matrix whose rows send one stream outside the alphabet and keep the other inside it. The second is provoked by three back-to-back vectors that change every setting. Every output is compared slot by slot with a model in the bench, which is built only from the rounding, clamping, validity and labelling rules above and applies each vector's own settings.

// File: rtl/lat_det_pkg.sv
package lat_det_pkg;

  typedef enum logic [1:0] {
    MODE_QPSK = 2'd0,
    MODE_Q16  = 2'd1,
    MODE_Q64  = 2'd2,
    MODE_RSV  = 2'd3
  } qam_mode_e;

  // LLR slots per stream: three label bits for each of the two dimensions
  localparam int SLOTS_PER_STREAM = 6;

endpackage

// File: rtl/lat_eq_quant.sv
module lat_eq_quant
  import lat_det_pkg::*;
#(
  parameter int NS      = 2,
  parameter int IN_W    = 12,
  parameter int RX_FRAC = 4,
  parameter int W_W     = 12,
  parameter int W_FRAC  = 8,
  parameter int T_W     = 4,
  parameter int EXP_W   = 3,
  parameter int Q_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [NS*2*IN_W-1:0]     rx,
  input  logic [NS*NS*2*W_W-1:0]   wmat,
  input  logic [NS*NS*2*T_W-1:0]   tmat,
  input  logic [EXP_W-1:0]         bfp_exp,
  input  qam_mode_e                mode,
  output logic                     a_valid,
  output logic [NS*2*Q_W-1:0]      q_vec,
  output logic [NS*NS*2*T_W-1:0]   t_vec,
  output qam_mode_e                a_mode
);

  localparam int ACC_W   = IN_W + W_W + $clog2(NS) + 2;
  localparam int BASE_SH = RX_FRAC + W_FRAC + 1;
  localparam int QLIM    = (1 << (Q_W - 1)) - 1;
  localparam int KMAX    = (QLIM - 1) / 2;

  // nearest odd integer after removing fraction and exponent; ties away from zero
  function automatic logic [Q_W-1:0] odd_round(input logic signed [ACC_W-1:0] v,
                                               input logic [EXP_W-1:0] e);
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] k;
    logic [Q_W-1:0]   odd;
    mag = v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
    k   = mag >> (BASE_SH + int'(e));
    if (k > ACC_W'(KMAX)) k = ACC_W'(KMAX);
    odd = Q_W'(k * 2 + 1);
    return v[ACC_W-1] ? Q_W'(-odd) : odd;
  endfunction

  logic [NS*2*Q_W-1:0] q_next;

  for (genvar r = 0; r < NS; r++) begin : g_row
    logic signed [ACC_W-1:0] acc_re, acc_im;
    always_comb begin
      acc_re = '0;
      acc_im = '0;
      for (int k = 0; k < NS; k++) begin
        acc_re = acc_re
               + ACC_W'($signed(wmat[((r*NS+k)*2)*W_W +: W_W]) * $signed(rx[(k*2)*IN_W +: IN_W]))
               - ACC_W'($signed(wmat[((r*NS+k)*2+1)*W_W +: W_W]) * $signed(rx[(k*2+1)*IN_W +: IN_W]));
        acc_im = acc_im
               + ACC_W'($signed(wmat[((r*NS+k)*2)*W_W +: W_W]) * $signed(rx[(k*2+1)*IN_W +: IN_W]))
               + ACC_W'($signed(wmat[((r*NS+k)*2+1)*W_W +: W_W]) * $signed(rx[(k*2)*IN_W +: IN_W]));
      end
    end
    assign q_next[(r*2)*Q_W +: Q_W]   = odd_round(acc_re, bfp_exp);
    assign q_next[(r*2+1)*Q_W +: Q_W] = odd_round(acc_im, bfp_exp);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      q_vec   <= '0;
      t_vec   <= '0;
      a_mode  <= MODE_QPSK;
    end else begin
      a_valid <= in_valid;
      if (in_valid) begin
        q_vec  <= q_next;
        t_vec  <= tmat;
        a_mode <= mode;
      end
    end
  end

  for (genvar i = 0; i < NS*2; i++) begin : g_chk
    // R4: every quantized coordinate handed to the remap stage is odd
    p_q_odd_r4 : assert property (@(posedge clk) disable iff (rst)
      a_valid |-> q_vec[i*Q_W]);
    // R5: quantized magnitude never exceeds the clamp limit
    p_q_bound_r5 : assert property (@(posedge clk) disable iff (rst)
      a_valid |-> ($signed(q_vec[i*Q_W +: Q_W]) >= -QLIM));
  end

endmodule

// File: rtl/lat_remap.sv
module lat_remap
  import lat_det_pkg::*;
#(
  parameter int NS  = 2,
  parameter int T_W = 4,
  parameter int Q_W = 6,
  parameter int S_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   a_valid,
  input  logic [NS*2*Q_W-1:0]    q_vec,
  input  logic [NS*NS*2*T_W-1:0] t_vec,
  input  qam_mode_e              a_mode,
  output logic                   b_valid,
  output logic [NS*2*S_W-1:0]    s_vec,
  output qam_mode_e              b_mode
);

  logic [NS*2*S_W-1:0] s_next;

  for (genvar r = 0; r < NS; r++) begin : g_row
    logic signed [S_W-1:0] s_re, s_im;
    always_comb begin
      s_re = '0;
      s_im = '0;
      for (int k = 0; k < NS; k++) begin
        s_re = s_re
             + S_W'($signed(t_vec[((r*NS+k)*2)*T_W +: T_W]) * $signed(q_vec[(k*2)*Q_W +: Q_W]))
             - S_W'($signed(t_vec[((r*NS+k)*2+1)*T_W +: T_W]) * $signed(q_vec[(k*2+1)*Q_W +: Q_W]));
        s_im = s_im
             + S_W'($signed(t_vec[((r*NS+k)*2)*T_W +: T_W]) * $signed(q_vec[(k*2+1)*Q_W +: Q_W]))
             + S_W'($signed(t_vec[((r*NS+k)*2+1)*T_W +: T_W]) * $signed(q_vec[(k*2)*Q_W +: Q_W]));
      end
    end
    assign s_next[(r*2)*S_W +: S_W]   = s_re;
    assign s_next[(r*2+1)*S_W +: S_W] = s_im;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      s_vec   <= '0;
      b_mode  <= MODE_QPSK;
    end else begin
      b_valid <= a_valid;
      if (a_valid) begin
        s_vec  <= s_next;
        b_mode <= a_mode;
      end
    end
  end

  // R10: a quantized vector always advances into the remap register on the next clock
  p_stage_follow_r10 : assert property (@(posedge clk) disable iff (rst)
    a_valid |=> b_valid && (b_mode == $past(a_mode)));

endmodule

// File: rtl/lat_demap.sv
module lat_demap
  import lat_det_pkg::*;
#(
  parameter int NS      = 2,
  parameter int S_W     = 12,
  parameter int LLR_W   = 6,
  parameter int LLR_MAG = 16
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  b_valid,
  input  logic [NS*2*S_W-1:0]                   s_vec,
  input  qam_mode_e                             b_mode,
  output logic                                  out_valid,
  output logic [NS*SLOTS_PER_STREAM*LLR_W-1:0]  llr
);

  localparam int TOT_W = NS * SLOTS_PER_STREAM * LLR_W;

  // returns {valid, b2, b1, b0} for one coordinate
  function automatic logic [3:0] dim_eval(input logic signed [S_W-1:0] a, input qam_mode_e m);
    logic [S_W-1:0] mag;
    logic           ok;
    logic [2:0]     b;
    mag = a[S_W-1] ? S_W'(-a) : S_W'(a);
    case (m)
      MODE_QPSK: ok = (mag == S_W'(1));
      MODE_Q16:  ok = (mag <= S_W'(3));
      MODE_Q64:  ok = (mag <= S_W'(7));
      default:   ok = 1'b0;
    endcase
    ok   = ok & a[0];
    b[0] = a[S_W-1];
    b[1] = (m == MODE_Q16) ? (mag == S_W'(1)) : (mag < S_W'(4));
    b[2] = (mag == S_W'(3)) || (mag == S_W'(5));
    return {ok, b};
  endfunction

  function automatic logic [LLR_W-1:0] slot_val(input logic bit_v, input logic used);
    if (!used) return '0;
    return bit_v ? LLR_W'(-LLR_MAG) : LLR_W'(LLR_MAG);
  endfunction

  logic [TOT_W-1:0] llr_next;
  logic [2:0]       used_mask;

  always_comb begin
    case (b_mode)
      MODE_QPSK: used_mask = 3'b001;
      MODE_Q16:  used_mask = 3'b011;
      default:   used_mask = 3'b111;
    endcase
  end

  for (genvar r = 0; r < NS; r++) begin : g_stream
    logic [3:0] ev_re, ev_im;
    logic       sym_ok;
    assign ev_re  = dim_eval($signed(s_vec[(r*2)*S_W +: S_W]), b_mode);
    assign ev_im  = dim_eval($signed(s_vec[(r*2+1)*S_W +: S_W]), b_mode);
    assign sym_ok = ev_re[3] & ev_im[3];
    for (genvar j = 0; j < 3; j++) begin : g_bit
      assign llr_next[(r*SLOTS_PER_STREAM+j)*LLR_W +: LLR_W] =
        slot_val(ev_re[j], sym_ok & used_mask[j]);
      assign llr_next[(r*SLOTS_PER_STREAM+3+j)*LLR_W +: LLR_W] =
        slot_val(ev_im[j], sym_ok & used_mask[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      llr       <= '0;
    end else begin
      out_valid <= b_valid;
      if (b_valid) llr <= llr_next;
    end
  end

  // R7: the reserved mode punctures every slot
  p_reserved_punct_r7 : assert property (@(posedge clk) disable iff (rst)
    (b_valid && b_mode == MODE_RSV) |=> (llr == '0));

  // R9: 4-QAM leaves the second and third label slots of each dimension empty
  for (genvar r = 0; r < NS; r++) begin : g_chk
    p_qpsk_slots_r9 : assert property (@(posedge clk) disable iff (rst)
      (b_valid && b_mode == MODE_QPSK) |=>
        (llr[(r*SLOTS_PER_STREAM+1)*LLR_W +: 2*LLR_W] == '0) &&
        (llr[(r*SLOTS_PER_STREAM+4)*LLR_W +: 2*LLR_W] == '0));
    for (genvar j = 0; j < SLOTS_PER_STREAM; j++) begin : g_slot
      // R9: every slot is zero or the fixed magnitude with either sign
      p_llr_levels_r9 : assert property (@(posedge clk) disable iff (rst)
        out_valid |->
          (llr[(r*SLOTS_PER_STREAM+j)*LLR_W +: LLR_W] == '0) ||
          (llr[(r*SLOTS_PER_STREAM+j)*LLR_W +: LLR_W] == LLR_W'(LLR_MAG)) ||
          (llr[(r*SLOTS_PER_STREAM+j)*LLR_W +: LLR_W] == LLR_W'(-LLR_MAG)));
    end
  end

endmodule

// File: rtl/lat_detector.sv
module lat_detector
  import lat_det_pkg::*;
#(
  parameter int NS      = 2,
  parameter int IN_W    = 12,
  parameter int RX_FRAC = 4,
  parameter int W_W     = 12,
  parameter int W_FRAC  = 8,
  parameter int T_W     = 4,
  parameter int EXP_W   = 3,
  parameter int Q_W     = 6,
  parameter int LLR_W   = 6,
  parameter int LLR_MAG = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid_i,
  input  logic [NS*2*IN_W-1:0]                 rx_i,
  input  logic [NS*NS*2*W_W-1:0]               wmat_i,
  input  logic [NS*NS*2*T_W-1:0]               tmat_i,
  input  logic [EXP_W-1:0]                     bfp_exp_i,
  input  logic [1:0]                           qam_mode_i,
  output logic                                 out_valid_o,
  output logic [NS*SLOTS_PER_STREAM*LLR_W-1:0] llr_o
);

  localparam int S_W = Q_W + T_W + $clog2(NS) + 1;

  logic                   a_valid, b_valid;
  logic [NS*2*Q_W-1:0]    q_vec;
  logic [NS*NS*2*T_W-1:0] t_vec;
  logic [NS*2*S_W-1:0]    s_vec;
  qam_mode_e              a_mode, b_mode;

  lat_eq_quant #(
    .NS(NS), .IN_W(IN_W), .RX_FRAC(RX_FRAC), .W_W(W_W), .W_FRAC(W_FRAC),
    .T_W(T_W), .EXP_W(EXP_W), .Q_W(Q_W)
  ) u_eq (
    .clk(clk), .rst(rst), .in_valid(in_valid_i), .rx(rx_i), .wmat(wmat_i),
    .tmat(tmat_i), .bfp_exp(bfp_exp_i), .mode(qam_mode_e'(qam_mode_i)),
    .a_valid(a_valid), .q_vec(q_vec), .t_vec(t_vec), .a_mode(a_mode)
  );

  lat_remap #(.NS(NS), .T_W(T_W), .Q_W(Q_W), .S_W(S_W)) u_remap (
    .clk(clk), .rst(rst), .a_valid(a_valid), .q_vec(q_vec), .t_vec(t_vec),
    .a_mode(a_mode), .b_valid(b_valid), .s_vec(s_vec), .b_mode(b_mode)
  );

  lat_demap #(.NS(NS), .S_W(S_W), .LLR_W(LLR_W), .LLR_MAG(LLR_MAG)) u_demap (
    .clk(clk), .rst(rst), .b_valid(b_valid), .s_vec(s_vec), .b_mode(b_mode),
    .out_valid(out_valid_o), .llr(llr_o)
  );

  // R2: an accepted vector leaves the block exactly three clocks later
  p_latency_r2 : assert property (@(posedge clk) disable iff (rst)
    in_valid_i |-> ##3 out_valid_o);

endmodule

// File: tb/lat_detector_tb_top.sv
module lat_detector_tb_top;

  localparam int NS      = 2;
  localparam int IN_W    = 12;
  localparam int RX_FRAC = 4;
  localparam int W_W     = 12;
  localparam int W_FRAC  = 8;
  localparam int T_W     = 4;
  localparam int EXP_W   = 3;
  localparam int LLR_W   = 6;
  localparam int LLR_MAG = 16;
  localparam int SLOTS   = 6;
  localparam int TOT_W   = NS * SLOTS * LLR_W;
  localparam int ONE_W   = 1 << W_FRAC;
  localparam int ONE_RX  = 1 << RX_FRAC;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   in_valid_i = 1'b0;
  logic [NS*2*IN_W-1:0]   rx_i = '0;
  logic [NS*NS*2*W_W-1:0] wmat_i = '0;
  logic [NS*NS*2*T_W-1:0] tmat_i = '0;
  logic [EXP_W-1:0]       bfp_exp_i = '0;
  logic [1:0]             qam_mode_i = '0;
  logic                   out_valid_o;
  logic [TOT_W-1:0]       llr_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // stimulus in integer form
  int y_re[NS], y_im[NS];
  int w_re[NS][NS], w_im[NS][NS];
  int t_re[NS][NS], t_im[NS][NS];
  int e_v, m_v;

  always #10 clk = ~clk;

  lat_detector #(
    .NS(NS), .IN_W(IN_W), .RX_FRAC(RX_FRAC), .W_W(W_W), .W_FRAC(W_FRAC),
    .T_W(T_W), .EXP_W(EXP_W), .Q_W(6), .LLR_W(LLR_W), .LLR_MAG(LLR_MAG)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .rx_i(rx_i), .wmat_i(wmat_i),
    .tmat_i(tmat_i), .bfp_exp_i(bfp_exp_i), .qam_mode_i(qam_mode_i),
    .out_valid_o(out_valid_o), .llr_o(llr_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic set_identity(input int mode);
    for (int r = 0; r < NS; r++) begin
      y_re[r] = ONE_RX; y_im[r] = ONE_RX;
      for (int k = 0; k < NS; k++) begin
        w_re[r][k] = (r == k) ? ONE_W : 0; w_im[r][k] = 0;
        t_re[r][k] = (r == k) ? 1 : 0;     t_im[r][k] = 0;
      end
    end
    e_v = 0; m_v = mode;
  endtask

  // nearest odd integer of acc / 2^(RX_FRAC+W_FRAC+e), ties away from zero, clamp 31
  function automatic int odd_q(input longint acc, input int e);
    longint mag, k;
    mag = (acc < 0) ? -acc : acc;
    k = mag >> (RX_FRAC + W_FRAC + 1 + e);
    if (k > 15) k = 15;
    return (acc < 0) ? -int'(2*k+1) : int'(2*k+1);
  endfunction

  function automatic logic [LLR_W-1:0] lv(input bit b, input bit used);
    if (!used) return '0;
    return b ? LLR_W'(-LLR_MAG) : LLR_W'(LLR_MAG);
  endfunction

  function automatic logic [TOT_W-1:0] model();
    logic [TOT_W-1:0] res;
    int qr[NS], qi[NS];
    res = '0;
    for (int r = 0; r < NS; r++) begin
      longint ar, ai;
      ar = 0; ai = 0;
      for (int k = 0; k < NS; k++) begin
        ar += longint'(w_re[r][k])*y_re[k] - longint'(w_im[r][k])*y_im[k];
        ai += longint'(w_re[r][k])*y_im[k] + longint'(w_im[r][k])*y_re[k];
      end
      qr[r] = odd_q(ar, e_v); qi[r] = odd_q(ai, e_v);
    end
    for (int r = 0; r < NS; r++) begin
      int s[2];
      bit ok;
      int lim;
      s[0] = 0; s[1] = 0;
      for (int k = 0; k < NS; k++) begin
        s[0] += t_re[r][k]*qr[k] - t_im[r][k]*qi[k];
        s[1] += t_re[r][k]*qi[k] + t_im[r][k]*qr[k];
      end
      lim = (m_v == 0) ? 1 : (m_v == 1) ? 3 : 7;
      ok = (m_v != 3);
      for (int d = 0; d < 2; d++) begin
        int a;
        a = (s[d] < 0) ? -s[d] : s[d];
        if ((s[d] & 1) == 0 || a > lim) ok = 0;
      end
      for (int d = 0; d < 2; d++) begin
        int a;
        bit b0, b1, b2;
        a  = (s[d] < 0) ? -s[d] : s[d];
        b0 = (s[d] < 0);
        b1 = (m_v == 1) ? (a == 1) : (a < 4);
        b2 = (a == 3) || (a == 5);
        res[(r*SLOTS+d*3+0)*LLR_W +: LLR_W] = lv(b0, ok);
        res[(r*SLOTS+d*3+1)*LLR_W +: LLR_W] = lv(b1, ok && m_v >= 1);
        res[(r*SLOTS+d*3+2)*LLR_W +: LLR_W] = lv(b2, ok && m_v >= 2);
      end
    end
    return res;
  endfunction

  task automatic drive();
    for (int k = 0; k < NS; k++) begin
      rx_i[(k*2)*IN_W +: IN_W]   = IN_W'(y_re[k]);
      rx_i[(k*2+1)*IN_W +: IN_W] = IN_W'(y_im[k]);
    end
    for (int r = 0; r < NS; r++)
      for (int k = 0; k < NS; k++) begin
        wmat_i[((r*NS+k)*2)*W_W +: W_W]   = W_W'(w_re[r][k]);
        wmat_i[((r*NS+k)*2+1)*W_W +: W_W] = W_W'(w_im[r][k]);
        tmat_i[((r*NS+k)*2)*T_W +: T_W]   = T_W'(t_re[r][k]);
        tmat_i[((r*NS+k)*2+1)*T_W +: T_W] = T_W'(t_im[r][k]);
      end
    bfp_exp_i  = EXP_W'(e_v);
    qam_mode_i = 2'(m_v);
    in_valid_i = 1'b1;
  endtask

  task automatic cmp_out(input string tag, input logic [TOT_W-1:0] expv);
    chk(out_valid_o === 1'b1, tag, "out_valid", longint'(out_valid_o), 1);
    for (int r = 0; r < NS; r++)
      chk(llr_o[r*SLOTS*LLR_W +: SLOTS*LLR_W] === expv[r*SLOTS*LLR_W +: SLOTS*LLR_W], tag,
          $sformatf("stream %0d llr", r),
          longint'(llr_o[r*SLOTS*LLR_W +: SLOTS*LLR_W]),
          longint'(expv[r*SLOTS*LLR_W +: SLOTS*LLR_W]));
  endtask

  // one isolated vector: drive, then compare three clocks later
  task automatic run_one(input string tag);
    logic [TOT_W-1:0] expv;
    @(negedge clk);
    drive();
    expv = model();
    @(negedge clk); in_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cmp_out(tag, expv);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid_o === 1'b0, "R1", "out_valid in reset", longint'(out_valid_o), 0);
    chk(llr_o === '0, "R1", "llr in reset", longint'(llr_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid_o === 1'b0 && llr_o === '0, "R1", "state after release",
        longint'(llr_o), 0);
  endtask

  task automatic t_gray_sweep();
    // R9 / R7 in every mode: walk coordinates through identity matrices
    for (int m = 0; m < 3; m++)
      for (int a = -9; a <= 9; a += 2) begin
        set_identity(m);
        y_re[0] = a*ONE_RX; y_im[0] = -a*ONE_RX;
        y_re[1] = -1*ONE_RX; y_im[1] = 3*ONE_RX;
        run_one($sformatf("R9 mode %0d coord %0d", m, a));
      end
  endtask

  task automatic t_equalize();
    // R3: complex, non-diagonal equalization matrix
    set_identity(2);
    w_re[0][0] = ONE_W/2; w_im[0][0] = ONE_W/2; w_re[0][1] = -ONE_W; w_im[0][1] = 0;
    w_re[1][0] = 0;       w_im[1][0] = ONE_W;   w_re[1][1] = ONE_W/4; w_im[1][1] = -ONE_W;
    y_re[0] = 5*ONE_RX; y_im[0] = -3*ONE_RX; y_re[1] = 2*ONE_RX; y_im[1] = 1*ONE_RX;
    run_one("R3 complex matrix");
  endtask

  task automatic t_rounding();
    // R4: ties at even values go away from zero, zero maps to +1
    set_identity(2);
    y_re[0] = 2*ONE_RX; y_im[0] = -2*ONE_RX; y_re[1] = 0; y_im[1] = 31;
    run_one("R4 ties and zero");
    set_identity(2);
    y_re[0] = 4*ONE_RX - 1; y_im[0] = -(4*ONE_RX - 1); y_re[1] = -1; y_im[1] = 6*ONE_RX;
    run_one("R4 below tie");
  endtask

  task automatic t_exponent();
    // R4: exponent divides the equalized value before rounding
    set_identity(2);
    y_re[0] = 6*ONE_RX; y_im[0] = -10*ONE_RX; y_re[1] = 12*ONE_RX; y_im[1] = 2*ONE_RX;
    e_v = 1;
    run_one("R4 exponent 1");
    set_identity(1);
    y_re[0] = 24*ONE_RX; y_im[0] = -8*ONE_RX; y_re[1] = 8*ONE_RX; y_im[1] = 8*ONE_RX;
    e_v = 3;
    run_one("R4 exponent 3");
  endtask

  task automatic t_clamp();
    // R5: a huge coordinate clamps to 31, seen through T row [1,-2] with q1 = 15
    set_identity(2);
    y_re[0] = 100*ONE_RX; y_im[0] = 1*ONE_RX; y_re[1] = 15*ONE_RX; y_im[1] = 1*ONE_RX;
    t_re[0][1] = -2;
    run_one("R5 clamp");
  endtask

  task automatic t_remap();
    // R6: complex integer transformation matrix
    set_identity(2);
    t_re[0][0] = 1; t_im[0][0] = 0; t_re[0][1] = 0; t_im[0][1] = 1;
    t_re[1][0] = 0; t_im[1][0] = 0; t_re[1][1] = 0; t_im[1][1] = -1;
    y_re[0] = 3*ONE_RX; y_im[0] = 1*ONE_RX; y_re[1] = 1*ONE_RX; y_im[1] = -5*ONE_RX;
    run_one("R6 complex T");
  endtask

  task automatic t_puncture();
    // R8: stream 0 lands on an even coordinate, stream 1 stays valid
    set_identity(1);
    t_re[0][1] = 1;
    y_re[0] = 1*ONE_RX; y_im[0] = 1*ONE_RX; y_re[1] = -3*ONE_RX; y_im[1] = 1*ONE_RX;
    run_one("R8 mixed streams");
    // R7: reserved mode punctures everything
    set_identity(3);
    run_one("R7 reserved mode");
  endtask

  task automatic t_pipeline();
    // R2 and R10: three back-to-back vectors with different settings
    logic [TOT_W-1:0] e0, e1, e2;
    @(negedge clk);
    set_identity(2); y_re[0] = 5*ONE_RX; y_im[0] = -7*ONE_RX;
    drive(); e0 = model();
    @(negedge clk);
    set_identity(0); y_re[1] = -1*ONE_RX; e_v = 2;
    y_re[0] = 4*ONE_RX; y_im[0] = -4*ONE_RX; y_im[1] = 3*ONE_RX;
    drive(); e1 = model();
    @(negedge clk);
    set_identity(1); t_re[1][0] = 2; y_re[0] = 1*ONE_RX; y_im[0] = -1*ONE_RX;
    y_re[1] = -5*ONE_RX; y_im[1] = 1*ONE_RX;
    drive(); e2 = model();
    @(negedge clk); in_valid_i = 1'b0;
    cmp_out("R10 first of burst", e0);
    @(negedge clk);
    cmp_out("R10 second of burst", e1);
    @(negedge clk);
    cmp_out("R2 third of burst", e2);
    @(negedge clk);
    chk(out_valid_o === 1'b0, "R2", "valid after burst", longint'(out_valid_o), 0);
    @(negedge clk);
    chk(out_valid_o === 1'b0 && llr_o === e2, "R2", "idle holds output",
        longint'(llr_o), longint'(e2));
  endtask

  initial begin
    set_identity(0);
    repeat (3) @(negedge clk);
    t_reset();
    t_gray_sweep();
    t_equalize();
    t_rounding();
    t_exponent();
    t_clamp();
    t_remap();
    t_puncture();
    t_pipeline();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule